// File: doc/BRIEF.md
# Configurable Output Macrocell

This block is the output stage that sits behind one column of a programmable AND array. It takes a set of product terms, one product term that enables the pin driver and one clear term that all macrocells share. The product terms are ORed together. Two configuration bits then decide what reaches the pin. The pin can show the OR result directly (combinational) or a copy held in a D flip-flop (registered), and either one can be active-high or active-low. The final driver inverts, so the polarity comes from choosing the true or the complemented mux input.

The block also returns a feedback signal to the array, in both true and complemented form. In combinational modes the feedback is the pin level: the driven value when the driver is on, and the external pin level when the driver is off. In registered modes the feedback is the complement of the flip-flop. The pin is modelled as a data output plus an enable. When the enable term is low the pin floats and `pin_in` becomes a plain input. The two configuration bits live in their own register, which software loads synchronously through `cfg_we`.

Top module: `mc_macrocell`

## Requirements
- R1: `cfg_sel` bit 1 is S1 and bit 0 is S0. With the mode S1S0=11 and `oe_term` high, `pin_out` equals the OR of all `N_TERMS` product terms, combinationally. `N_TERMS` is even and lies between 8 and 16.
- R2: With the mode S1S0=10 and `oe_term` high, `pin_out` is the inverse of that OR, combinationally.
- R3: The flip-flop loads the OR on every rising clock edge. With the mode S1S0=01 and `oe_term` high, `pin_out` equals the flip-flop.
- R4: With the mode S1S0=00 and `oe_term` high, `pin_out` is the inverse of the flip-flop.
- R5: While `clr_term` is high the flip-flop is zero. It clears without waiting for a clock edge and ignores edges until `clr_term` falls.
- R6: `pin_oe` follows `oe_term`. While `oe_term` is low, `pin_out` is 0.
- R7: When S1=1, `fb_true` equals `pin_out` if `oe_term` is high and `pin_in` if it is low. `fb_comp` is always the inverse of `fb_true`.
- R8: When S1=0, `fb_true` is the inverse of the flip-flop and `fb_comp` equals the flip-flop, whatever `pin_in` is.
- R9: The mode register takes `cfg_sel` on a rising edge where `cfg_we` is high, and keeps its value on every other edge. The new mode acts only after that edge.
- R10: After reset the mode is S1S0=11 (combinational, active-high).
- R11: In combinational modes `clr_term` has no effect on `pin_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load strobe for the mode register |
| cfg_sel | input | 2 | New mode, bit 1 = S1, bit 0 = S0 |
| terms | input | N_TERMS | Product terms to be ORed |
| oe_term | input | 1 | Product term that enables the pin driver |
| clr_term | input | 1 | Shared clear term for the flip-flop |
| pin_in | input | 1 | External pin level |
| pin_out | output | 1 | Driven pin value |
| pin_oe | output | 1 | Pin driver enable |
| fb_true | output | 1 | Feedback to the array, true form |
| fb_comp | output | 1 | Feedback to the array, complemented form |

## Verification
The flip-flop capture check assumes that any pulse on `clr_term` spans at least one rising edge. Without that, a short pulse between two edges would clear the flip-flop while no edge saw the clear. The bench drives every input on the falling edge and holds each clear pulse across a rising edge, so it stays inside this assumption. It then sweeps all 256 term patterns with varying enable and pin levels through each of the four modes.

// File: rtl/mc_pkg.sv
package mc_pkg;
  // Bit 1 is S1 (0 = registered, 1 = combinational), bit 0 is S0.
  typedef enum logic [1:0] {
    MODE_REG_LO  = 2'b00,
    MODE_REG_HI  = 2'b01,
    MODE_COMB_LO = 2'b10,
    MODE_COMB_HI = 2'b11
  } mc_mode_e;

  function automatic logic mode_is_comb(input mc_mode_e m);
    return m[1];
  endfunction
endpackage

// File: rtl/mc_rst_sync.sv
module mc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/mc_cfg_reg.sv
module mc_cfg_reg
  import mc_pkg::*;
#(
  parameter mc_mode_e RST_MODE = MODE_COMB_HI
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     we,
  input  logic [1:0] sel_in,
  output mc_mode_e mode_q
);
  mc_mode_e mode_d;

  always_comb begin
    mode_d = mode_q;
    if (we) mode_d = mc_mode_e'(sel_in);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= RST_MODE;
    else        mode_q <= mode_d;
  end

  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(we)) |-> (mode_q == mc_mode_e'($past(sel_in)))); // R9
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(we)) |-> $stable(mode_q)); // R9
endmodule

// File: rtl/mc_sum_tree.sv
module mc_sum_tree #(
  parameter int N_TERMS = 8
) (
  input  logic [N_TERMS-1:0] terms,
  output logic               sum_o
);
  localparam int N_PAIRS = N_TERMS / 2;

  if ((N_TERMS < 8) || (N_TERMS > 16) || (N_TERMS % 2 != 0)) begin : g_bad_count
    $error("N_TERMS must be even and within 8..16");
  end

  logic [N_PAIRS-1:0] pair_or;

  for (genvar g = 0; g < N_PAIRS; g++) begin : g_pair
    assign pair_or[g] = terms[2*g] | terms[2*g+1];
  end

  assign sum_o = |pair_or;
endmodule

// File: rtl/mc_store.sv
module mc_store (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic d_i,
  output logic q_o
);
  logic q_d;

  always_comb begin
    q_d = d_i;
  end

  always_ff @(posedge clk or negedge rst_n or posedge clr_i) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (clr_i) q_o <= 1'b0;
    else            q_o <= q_d;
  end

  AST_CLR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |-> !q_o); // R5
  AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !clr_i && !$past(clr_i)) |-> (q_o == $past(d_i))); // R3
endmodule

// File: rtl/mc_out_stage.sv
module mc_out_stage
  import mc_pkg::*;
(
  input  mc_mode_e mode,
  input  logic     q_i,
  input  logic     sum_i,
  input  logic     oe_i,
  input  logic     pad_in,
  output logic     pad_out,
  output logic     pad_oe,
  output logic     fb_t,
  output logic     fb_c
);
  logic mux4;
  logic drv;
  logic pad_lvl;
  logic fb_sel;

  // The four mux inputs: flip-flop true and complement, OR true and complement.
  always_comb begin
    unique case (mode)
      MODE_REG_LO:  mux4 = q_i;
      MODE_REG_HI:  mux4 = ~q_i;
      MODE_COMB_LO: mux4 = sum_i;
      default:      mux4 = ~sum_i;
    endcase
  end

  // The driver inverts.
  assign drv     = ~mux4;
  assign pad_oe  = oe_i;
  assign pad_out = oe_i & drv;

  // The pin level: our own drive when enabled, the external level when not.
  assign pad_lvl = oe_i ? drv : pad_in;

  always_comb begin
    if (mode_is_comb(mode)) fb_sel = pad_lvl;
    else                    fb_sel = ~q_i;
  end

  assign fb_t = fb_sel;
  assign fb_c = ~fb_sel;
endmodule

// File: rtl/mc_macrocell.sv
module mc_macrocell
  import mc_pkg::*;
#(
  parameter int       N_TERMS  = 8,
  parameter mc_mode_e RST_MODE = MODE_COMB_HI
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_sel,
  input  logic [N_TERMS-1:0] terms,
  input  logic               oe_term,
  input  logic               clr_term,
  input  logic               pin_in,
  output logic               pin_out,
  output logic               pin_oe,
  output logic               fb_true,
  output logic               fb_comp
);
  logic     rst_sync_n;
  mc_mode_e mode;
  logic     sum;
  logic     q;

  mc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  mc_cfg_reg #(.RST_MODE(RST_MODE)) u_cfg (
    .clk(clk), .rst_n(rst_sync_n), .we(cfg_we), .sel_in(cfg_sel), .mode_q(mode)
  );

  mc_sum_tree #(.N_TERMS(N_TERMS)) u_sum (
    .terms(terms), .sum_o(sum)
  );

  mc_store u_ff (
    .clk(clk), .rst_n(rst_sync_n), .clr_i(clr_term), .d_i(sum), .q_o(q)
  );

  mc_out_stage u_out (
    .mode(mode), .q_i(q), .sum_i(sum), .oe_i(oe_term), .pad_in(pin_in),
    .pad_out(pin_out), .pad_oe(pin_oe), .fb_t(fb_true), .fb_c(fb_comp)
  );

  AST_COMB_ACTIVE_HIGH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode == MODE_COMB_HI && oe_term) |-> (pin_out == (|terms))); // R1
  AST_COMB_ACTIVE_LOW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode == MODE_COMB_LO && oe_term) |-> (pin_out != (|terms))); // R2
  AST_REG_FOLLOW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode == MODE_REG_HI && oe_term) |-> (pin_out == q)); // R3
  AST_FB_PIN_INPUT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode[1] && !oe_term) |-> (fb_true == pin_in)); // R7
  AST_FB_REG: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!mode[1]) |-> (fb_comp == q)); // R8
endmodule

// File: tb/mc_macrocell_tb.sv
module mc_macrocell_tb;
  localparam int CLK_P = 10;
  localparam int NT    = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_we;
  logic [1:0]    cfg_sel;
  logic [NT-1:0] terms;
  logic          oe_term, clr_term, pin_in;
  logic          pin_out, pin_oe, fb_true, fb_comp;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  mc_macrocell #(.N_TERMS(NT)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .terms(terms), .oe_term(oe_term), .clr_term(clr_term), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .fb_true(fb_true), .fb_comp(fb_comp)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic set_cfg(input logic [1:0] v);
    @(negedge clk);
    cfg_we  = 1'b1;
    cfg_sel = v;
    @(posedge clk);
    #1;
    cfg_we  = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic q_exp, sum_exp, drv_exp;
    string tag;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = 2'b00; terms = '0;
    oe_term = 1'b1; clr_term = 1'b0; pin_in = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R10: the reset mode is combinational active-high
    @(negedge clk) terms = 8'h10;
    #1 chk("R10 reset mode, term high", pin_out, 1'b1);
    terms = 8'h00;
    #1 chk("R10 reset mode, terms low", pin_out, 1'b0);

    // R9: the write takes effect only at the edge
    @(negedge clk);
    terms = 8'h01; cfg_we = 1'b1; cfg_sel = 2'b10;
    #1 chk("R9 before load edge", pin_out, 1'b1);
    @(posedge clk); #1;
    cfg_we = 1'b0;
    chk("R9 after load edge", pin_out, 1'b0);
    @(negedge clk) cfg_sel = 2'b11;
    repeat (2) @(posedge clk);
    #1 chk("R9 hold without we", pin_out, 1'b0);

    // Sweep of every mode and every term pattern (R1..R4, R6..R8)
    for (int m = 0; m < 4; m++) begin
      set_cfg(m[1:0]);
      for (int p = 0; p < 256; p++) begin
        @(negedge clk);
        terms   = p[NT-1:0];
        oe_term = (p % 3 != 0);
        pin_in  = p[0] ^ p[5];
        sum_exp = (p != 0);
        if (m >= 2) begin
          #1;
        end else begin
          @(posedge clk); #1;
          q_exp = sum_exp;
        end
        case (m)
          0: begin drv_exp = ~q_exp;   tag = "R4 registered active-low";    end
          1: begin drv_exp = q_exp;    tag = "R3 registered active-high";   end
          2: begin drv_exp = ~sum_exp; tag = "R2 combinational active-low"; end
          default: begin drv_exp = sum_exp; tag = "R1 combinational active-high"; end
        endcase
        chk(tag, pin_out, oe_term & drv_exp);
        chk("R6 enable follows term", pin_oe, oe_term);
        if (m >= 2) begin
          chk("R7 pin feedback", fb_true, oe_term ? drv_exp : pin_in);
          chk("R7 feedback complement", fb_comp, ~fb_true);
        end else begin
          chk("R8 register feedback true", fb_true, ~q_exp);
          chk("R8 register feedback comp", fb_comp, q_exp);
        end
      end
    end

    // R5: asynchronous clear in the registered active-high mode
    set_cfg(2'b01);
    @(negedge clk) begin terms = 8'hFF; oe_term = 1'b1; end
    @(posedge clk); #1 chk("R5 set before clear", pin_out, 1'b1);
    @(negedge clk); #2 clr_term = 1'b1;
    #1 chk("R5 clear without edge", pin_out, 1'b0);
    @(posedge clk); #1 chk("R5 clear holds over edge", pin_out, 1'b0);
    @(negedge clk) clr_term = 1'b0;
    #1 chk("R5 still clear after release", pin_out, 1'b0);
    @(posedge clk); #1 chk("R5 captures after release", pin_out, 1'b1);

    // R11: the clear term does not touch combinational output
    set_cfg(2'b11);
    @(negedge clk) begin terms = 8'h80; clr_term = 1'b1; end
    #1 chk("R11 clear ignored, active-high", pin_out, 1'b1);
    @(posedge clk); #1 chk("R11 clear ignored after edge", pin_out, 1'b1);
    @(negedge clk) clr_term = 1'b0;
    set_cfg(2'b10);
    @(negedge clk) begin terms = 8'h00; clr_term = 1'b1; end
    #1 chk("R11 clear ignored, active-low", pin_out, 1'b1);
    @(negedge clk) clr_term = 1'b0;

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule